// File: doc/BRIEF.md
# Timestamped Hit Compressor

The block watches several groups of 32 discriminated wire inputs, sampled on a 50 MHz clock. A wire produces a hit when it reads 1 in the current sample after reading 0 in the previous one, so a wire held high produces only one hit. A per-wire mask forces selected wires to 0 before this detection. A coarse time counter runs at one fifth of the clock rate. A 5-bit unit number is supplied by the system, and each group's 4-bit connector number is its index.

In every clock cycle where a group has at least one hit, the group produces a two-word record: a packed header word, then the 32-bit hit pattern. All groups are served in the same cycle. Their records are laid into the buffer in ascending group order, so sampling never stalls.

A record that does not fit in the free buffer space is dropped whole, and a sticky overflow flag is raised. Downstream logic drains the buffer one word at a time through a valid/read port.

Top module: `hit_compressor`

## Requirements
- R1: After reset the read port shows no valid word and the overflow flag is 0.
- R2: A wire bit produces a hit only in the sample where it reads 1 and read 0 in the previous sample. A wire held high produces one record, and a falling wire produces none.
- R3: A wire whose mask bit is 1 reads as 0. A masked rising wire gives no hit. Unmasking a wire that is held high gives one hit on the first unmasked sample.
- R4: The time counter advances once every 5 clock cycles. When time_clr_i is sampled high, the counter is 0 after that edge. A wire first sampled high m edges after the clear or reset carries time stamp floor(m/5).
- R5: Header word layout:
  - bits [31:10] hold the time counter, zero-extended;
  - bits [9:5] hold unit_i;
  - bits [4:1] hold the group index (group g owns wires_i[32g+31:32g]);
  - bit 0 is 0.
- R6: A record is its header word followed by the group's 32-bit hit pattern. Wires sampled at clock edge k are readable after edge k+2.
- R7: When several groups hit in the same sample, their records enter the buffer in ascending group order.
- R8: Hits on consecutive samples each produce their own record, with no dead time.
- R9: The buffer holds DEPTH words, and a completely full buffer raises no overflow. A record is written whole or not at all. Any dropped record sets ovfl_o, which stays set until reset.
- R10: rd_valid_o is 1 whenever the buffer is non-empty. A read request advances to the next word. A read request while the buffer is empty has no effect.
- R11: The time counter wraps silently from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| time_clr_i | input | 1 | Synchronous clear of the time counter |
| unit_i | input | 5 | Unit number placed in every header |
| wires_i | input | 32*N_GROUPS | Wire inputs, group g in bits [32g+31:32g] |
| mask_i | input | 32*N_GROUPS | Per-wire mask, 1 forces the wire to 0 |
| rd_i | input | 1 | Pop the current word |
| rd_data_o | output | 32 | Word at the head of the buffer |
| rd_valid_o | output | 1 | Buffer is non-empty |
| ovfl_o | output | 1 | Sticky record-drop flag |

## Verification
The hardest state to reach from the ports is a partial overflow, where some records in a single sample still fit and the rest do not. The bench uses a 16-word buffer and pre-fills it to 14 words with bursts from all groups, then from three groups. A final four-group burst must leave exactly the lowest group's record and drop the other three. Draining the buffer afterwards confirms that no fragment of a dropped record was written and that the order was kept. The counter wrap is reached by shrinking the time counter to 6 bits, and every one of the 128 wires is swept individually.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned STAMP_W = 22;
  localparam int unsigned UNIT_W  = 5;
  localparam int unsigned CONN_W  = 4;

  function automatic logic [WORD_W-1:0] pack_hdr(input logic [STAMP_W-1:0] stamp,
                                                  input logic [UNIT_W-1:0]  unit,
                                                  input logic [CONN_W-1:0]  conn);
    return {stamp, unit, conn, 1'b0};
  endfunction
endpackage

// File: rtl/hc_timebase.sv
module hc_timebase #(
  parameter int unsigned DIV    = 5,
  parameter int unsigned TIME_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  output logic [TIME_W-1:0] time_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0]     pre_q;
  logic [TIME_W-1:0] time_q;
  logic              tick;

  assign tick   = (pre_q == PW'(DIV - 1));
  assign time_o = time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      time_q <= '0;
    end else if (clr_i) begin
      pre_q  <= '0;
      time_q <= '0;
    end else if (tick) begin
      pre_q  <= '0;
      time_q <= time_q + TIME_W'(1);
    end else begin
      pre_q  <= pre_q + PW'(1);
    end
  end

  // R4
  tb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && pre_q != PW'(DIV - 1)) |=> $stable(time_q));
  // R4
  tb_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (time_q == '0));
  // R11
  tb_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && pre_q == PW'(DIV - 1) && time_q == '1) |=> (time_q == '0));
endmodule

// File: rtl/hc_edge.sv
module hc_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wires_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] samp_q, prev_q, hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      prev_q <= '0;
      hit_q  <= '0;
    end else begin
      samp_q <= wires_i & ~mask_i;
      prev_q <= samp_q;
      hit_q  <= samp_q & ~prev_q;
    end
  end

  assign hit_o = hit_q;

  // R2
  edge_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit_q & ~prev_q) == '0));
  // R3
  edge_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((samp_q & $past(mask_i)) == '0));
endmodule

// File: rtl/hc_fifo.sv
module hc_fifo #(
  parameter int unsigned NG    = 4,
  parameter int unsigned DEPTH = 512
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NG-1:0]        vld_i,
  input  logic [NG-1:0][31:0]  hdr_i,
  input  logic [NG-1:0][31:0]  pat_i,
  input  logic                 rd_i,
  output logic [31:0]          rd_data_o,
  output logic                 rd_valid_o,
  output logic                 ovfl_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [31:0]        mem [DEPTH];
  logic [AW-1:0]      wp_q, rp_q;
  logic [CW-1:0]      cnt_q;
  logic               ovfl_q;
  logic [NG-1:0]      acc;
  logic [NG-1:0][AW-1:0] off;
  logic [CW:0]        used, free_w;
  logic               pop;

  assign free_w = (CW+1)'(DEPTH) - (CW+1)'(cnt_q);
  assign pop    = rd_i && (cnt_q != '0);

  // Whole-record admission in group order against free space at this edge.
  always_comb begin
    used = '0;
    acc  = '0;
    off  = '0;
    for (int g = 0; g < int'(NG); g++) begin
      if (vld_i[g] && (free_w >= used + (CW+1)'(2))) begin
        acc[g] = 1'b1;
        off[g] = AW'(used);
        used   = used + (CW+1)'(2);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int g = 0; g < int'(NG); g++) begin
      if (acc[g]) begin
        mem[wp_q + off[g]]          <= hdr_i[g];
        mem[wp_q + off[g] + AW'(1)] <= pat_i[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      ovfl_q <= 1'b0;
    end else begin
      wp_q   <= wp_q + AW'(used);
      rp_q   <= rp_q + AW'(pop);
      cnt_q  <= cnt_q + CW'(used) - CW'(pop);
      ovfl_q <= ovfl_q | (|(vld_i & ~acc));
    end
  end

  assign rd_data_o  = mem[rp_q];
  assign rd_valid_o = (cnt_q != '0);
  assign ovfl_o     = ovfl_q;

  // R9
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R9
  fifo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovfl_q |=> ovfl_q);
  // R9
  fifo_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i != acc) |=> ovfl_q);
  // R10
  fifo_empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && rd_i && vld_i == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/hit_compressor.sv
module hit_compressor #(
  parameter int unsigned N_GROUPS = 4,
  parameter int unsigned DEPTH    = 512,
  parameter int unsigned TIME_W   = 22,
  parameter int unsigned DIV      = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    time_clr_i,
  input  logic [4:0]              unit_i,
  input  logic [32*N_GROUPS-1:0]  wires_i,
  input  logic [32*N_GROUPS-1:0]  mask_i,
  input  logic                    rd_i,
  output logic [31:0]             rd_data_o,
  output logic                    rd_valid_o,
  output logic                    ovfl_o
);
  import hc_pkg::*;

  logic [TIME_W-1:0]           time_now, stamp_q;
  logic [N_GROUPS-1:0][31:0]   hit;
  logic [N_GROUPS-1:0][31:0]   hdr;
  logic [N_GROUPS-1:0]         vld;

  hc_timebase #(.DIV(DIV), .TIME_W(TIME_W)) u_tb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (time_clr_i),
    .time_o(time_now)
  );

  // Stamp lines up with the registered hit patterns.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stamp_q <= '0;
    else         stamp_q <= time_now;
  end

  for (genvar g = 0; g < int'(N_GROUPS); g++) begin : g_grp
    hc_edge #(.W(32)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wires_i(wires_i[32*g +: 32]),
      .mask_i (mask_i[32*g +: 32]),
      .hit_o  (hit[g])
    );
    assign vld[g] = |hit[g];
    assign hdr[g] = pack_hdr(STAMP_W'(stamp_q), unit_i, CONN_W'(g));
  end

  hc_fifo #(.NG(N_GROUPS), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (vld),
    .hdr_i     (hdr),
    .pat_i     (hit),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o),
    .ovfl_o    (ovfl_o)
  );
endmodule

// File: tb/hit_compressor_test.sv
`timescale 1ns/1ps
module hit_compressor_test;
  localparam int NG = 4;
  localparam int DEPTH = 16;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [4:0] unit = 5'h15;
  logic [32*NG-1:0] wires = '0;
  logic [32*NG-1:0] mask = '0;
  logic rd = 1'b0;
  logic [31:0] rd_data;
  logic rd_valid, ovfl;

  int n_tests = 0;
  int n_fail = 0;
  int edge_n = 0;
  int c0 = 0;
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  hit_compressor #(.N_GROUPS(NG), .DEPTH(DEPTH), .TIME_W(TW), .DIV(5)) uut (
    .clk_i(clk), .rst_ni(rst_n), .time_clr_i(clr), .unit_i(unit),
    .wires_i(wires), .mask_i(mask), .rd_i(rd),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .ovfl_o(ovfl)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] hdr_of(input int k, input int g);
    logic [21:0] t;
    t = 22'((((k - c0) / 5) % (1 << TW)));
    return {t, unit, 4'(g), 1'b0};
  endfunction

  task automatic push_rec(input int k, input logic [32*NG-1:0] pat, input logic [NG-1:0] keep);
    for (int g = 0; g < NG; g++) begin
      if (keep[g] && pat[32*g +: 32] != '0) begin
        exp_q.push_back(hdr_of(k, g));
        exp_q.push_back(pat[32*g +: 32]);
      end
    end
  endtask

  // One-sample pulse; expected records use the edge that samples it.
  task automatic pulse(input logic [32*NG-1:0] pat, input logic [NG-1:0] keep);
    int k;
    @(negedge clk);
    wires = pat;
    @(negedge clk);
    k = edge_n;
    wires = '0;
    push_rec(k, pat & ~mask, keep);
  endtask

  task automatic drain(input string req);
    int n;
    repeat (3) @(negedge clk);
    n = 0;
    while (rd_valid && n < 40) begin
      got_q.push_back(rd_data);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      n++;
    end
    check(got_q.size() == exp_q.size(), req, 32'(got_q.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] === exp_q[i], req, got_q[i], exp_q[i]);
    exp_q.delete();
    got_q.delete();
  endtask

  task automatic clear_time;
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    c0 = edge_n;
    clr = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    c0 = edge_n;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #4000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
    check(ovfl == 1'b0, "R1 ovfl", 32'(ovfl), 0);
    rst_n = 1'b1;
    c0 = edge_n;

    // R5 R6 sweep every wire of every group; stamps also cover R4, R11
    for (int g = 0; g < NG; g++) begin
      for (int w = 0; w < 32; w++) begin
        logic [32*NG-1:0] p;
        p = '0;
        p[32*g + w] = 1'b1;
        pulse(p, 4'hF);
        drain("R5 R6 single wire");
      end
    end

    // R4 clear then precise stamps
    unit = 5'h0A;
    clear_time();
    pulse(128'h1, 4'hF);
    drain("R4 stamp after clear");
    clear_time();
    repeat (3) @(negedge clk);
    pulse(128'h2, 4'hF);
    drain("R4 stamp five ticks");

    // R11 wrap of the 6-bit counter
    clear_time();
    repeat (330) @(negedge clk);
    pulse(128'h4, 4'hF);
    drain("R11 wrap");

    // R2 held high yields one record, falling yields none
    begin
      int k;
      @(negedge clk);
      wires = 128'h80;
      @(negedge clk);
      k = edge_n;
      push_rec(k, 128'h80, 4'hF);
      repeat (10) @(negedge clk);
      wires = '0;
      drain("R2 held high");
      repeat (4) @(negedge clk);
      check(rd_valid == 1'b0, "R2 falling edge", 32'(rd_valid), 0);
    end

    // R3 masked wire gives nothing; unmask while high gives one hit
    mask = '0;
    mask[35] = 1'b1;
    pulse(128'h1 << 35, 4'hF);
    drain("R3 masked pulse");
    begin
      int k;
      @(negedge clk);
      wires = 128'h1 << 35;
      repeat (3) @(negedge clk);
      mask = '0;
      @(negedge clk);
      k = edge_n;
      push_rec(k, 128'h1 << 35, 4'hF);
      repeat (3) @(negedge clk);
      wires = '0;
      drain("R3 unmask held wire");
    end
    mask = '0;
    mask[64 +: 32] = 32'h0F0F_00FF;
    pulse({32'h0, 32'hFFFF_FFFF, 64'h0}, 4'hF);
    drain("R3 partial mask");
    mask = '0;

    // R7 all groups in one sample, ascending order
    pulse({32'hDEAD_0001, 32'h0BAD_0002, 32'h1234_5678, 32'h8000_0001}, 4'hF);
    drain("R7 group order");

    // R8 consecutive samples, no dead time
    begin
      int k;
      @(negedge clk);
      wires = 128'h1;
      @(negedge clk);
      k = edge_n; push_rec(k, 128'h1, 4'hF);
      wires = 128'h2;
      @(negedge clk);
      k = edge_n; push_rec(k, 128'h2, 4'hF);
      wires = 128'h4;
      @(negedge clk);
      k = edge_n; push_rec(k, 128'h4, 4'hF);
      wires = '0;
      drain("R8 back to back");
    end

    // R10 read while empty has no effect
    @(negedge clk);
    rd = 1'b1;
    repeat (3) @(negedge clk);
    rd = 1'b0;
    check(rd_valid == 1'b0, "R10 empty read", 32'(rd_valid), 0);
    pulse(128'h10 << 64, 4'hF);
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b1, "R10 valid when non-empty", 32'(rd_valid), 1);
    drain("R10 read after empty read");

    // R9 fill to exactly full, then partial drop of one burst
    pulse({32'h11, 32'h22, 32'h33, 32'h44}, 4'hF);
    pulse({32'h0, 32'h55, 32'h66, 32'h77}, 4'hF);
    pulse({32'h88, 32'h99, 32'hAA, 32'hBB}, 4'h1);
    repeat (3) @(negedge clk);
    check(ovfl == 1'b1, "R9 overflow set", 32'(ovfl), 1);
    drain("R9 whole records kept");
    check(ovfl == 1'b1, "R9 overflow sticky", 32'(ovfl), 1);

    do_reset();
    repeat (2) @(negedge clk);
    check(ovfl == 1'b0, "R9 full without drop", 32'(ovfl), 0);
    pulse({32'h1, 32'h2, 32'h4, 32'h8}, 4'hF);
    pulse({32'h10, 32'h20, 32'h40, 32'h80}, 4'hF);
    repeat (3) @(negedge clk);
    check(ovfl == 1'b0, "R9 exactly full no overflow", 32'(ovfl), 0);
    drain("R9 full contents");

    do_reset();
    @(negedge clk);
    check(rd_valid == 1'b0, "R1 rd_valid after reset", 32'(rd_valid), 0);
    check(ovfl == 1'b0, "R1 ovfl after reset", 32'(ovfl), 0);
    summary();
  end
endmodule